// File: doc/BRIEF.md
# NAND Flash Command-Level Device Model

This block is a synthesizable model of a small NAND flash device as a controller sees it. The controller reaches it through three strobed byte inputs: one for commands, one for address bytes and one for write data. A read strobe consumes the byte shown on the read-data output. A write-protect input completes the interface. Inside, a command decoder drives an address tracker, a page program buffer and a register-array store. The page size, the page count and the pages per erase block are parameters.

The block is meant for system tests of flash controllers that must see real command sequencing without timing or busy behaviour. Reads stream bytes from the addressed page. Programming collects bytes and then clears bits: each buffered byte is ANDed into the page, as on real cells, and nothing is overwritten. An erase sets a whole block back to 0xFF. A parameter selects the addressing scheme. Small-page addressing takes one column byte, with the high column bits coming from an area-pointer command. Large-page addressing takes two column bytes, and the area-pointer commands are rejected.

The read-data output always shows the byte that the next read strobe will consume. So the controller samples `rd_data` and pulses `rd_re` in the same cycle.

Top module: `nand_cmd_model`

## Requirements
- R1: After reset the block is idle: `rd_data` is 0x00, `prot_err` is low and the array holds 0xFF in every byte.
- R2: Command 0x00 enters read mode with area pointer 0. Each read strobe consumes the byte at the current row and column, and the column then advances by one. When the column is at or beyond the page size, `rd_data` is 0x00 and a read strobe leaves the column unchanged.
- R3: With small-page addressing (LARGE_PAGE=0), 0x01 selects area pointer 1 and 0x50 selects area pointer 2. Both enter read mode. The first address byte sets column = area*256 + byte, and the next byte is the least significant row byte. This first byte clears bit 0 of the area pointer, so 0x01 applies once and 0x50 persists.
- R4: With large-page addressing (LARGE_PAGE=1), address bytes 0 and 1 are the low and high column bytes. Later bytes fill the row from its least significant byte up, and the row keeps only as many bits as the page count needs. Commands 0x01 and 0x50 leave the state unchanged.
- R5: Command 0x80 enters program setup, empties the buffer and takes address bytes from column byte 0. A data byte is buffered only while (buffered count + column) is below the page size; any other data byte is dropped.
- R6: Command 0x10 acts only in program setup. It ANDs buffered byte k into the page byte at column+k of the current row and then enters idle, where reads return 0x00. In any other state it has no effect.
- R7: Command 0x60 enters erase setup and takes address bytes as row bytes. Command 0xD0 acts only in erase setup. It writes 0xFF to every page of the block holding the row, clears the row's page-in-block bits and enters idle.
- R8: In status mode (command 0x70), `rd_data` is 0x40 with bit 7 set when `wr_prot` is low.
- R9: After command 0x90, the first read gives MFR_CODE and the second gives DEV_CODE. The block is then idle.
- R10: Command 0xFF clears row, column and area pointer and enters idle. Commands 0xFF, 0x70 and 0x90 each make later address bytes change nothing until a command restarts address collection.
- R11: A program or erase confirm given while `wr_prot` is high leaves the array unchanged, still enters idle, and raises `prot_err` for exactly the next cycle.
- R12: When strobes coincide, only one acts, by the priority command, then address, then data write, then read. The others in that cycle are ignored.
- R13: Command bytes with no defined meaning (for example 0x30 or 0x42) change neither the state nor the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command code |
| addr_we | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte |
| wr_we | input | 1 | Data write strobe |
| wr_byte | input | 8 | Data byte for the program buffer |
| rd_re | input | 1 | Read strobe; consumes the byte on rd_data |
| rd_data | output | 8 | Byte the next read strobe consumes |
| wr_prot | input | 1 | Write protect, active high |
| prot_err | output | 1 | One-cycle pulse on a confirm refused by write protect |

## Verification
Two functions can land in the same cycle: a command strobe together with a read or address strobe, and an address strobe together with a data write. The bench provokes both on purpose. It fires 0x70 while pulsing a read in read mode, then returns to read mode without sending an address, and expects the byte at the column that has not advanced. It also sends an address byte together with a data byte during program setup, confirms, and expects the page to stay erased because the data byte was dropped.

// File: rtl/nfm_pkg.sv
package nfm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_PROG  = 3'd2,
    ST_ERASE = 3'd3,
    ST_STAT  = 3'd4,
    ST_ID0   = 3'd5,
    ST_ID1   = 3'd6
  } nfm_state_e;

  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_AREA1  = 8'h01;
  localparam logic [7:0] OP_AREA2  = 8'h50;
  localparam logic [7:0] OP_PCONF  = 8'h10;
  localparam logic [7:0] OP_ESETUP = 8'h60;
  localparam logic [7:0] OP_PSETUP = 8'h80;
  localparam logic [7:0] OP_ECONF  = 8'hD0;
  localparam logic [7:0] OP_RESET  = 8'hFF;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_IDENT  = 8'h90;

  localparam int          ACNT_W    = 3;
  localparam logic [2:0]  ACNT_COL0 = 3'd0;
  localparam logic [2:0]  ACNT_ROW0 = 3'd2;
  localparam logic [2:0]  ACNT_DONE = 3'd6;

  localparam int          COL_W     = 16;

endpackage

// File: rtl/nfm_addr_track.sv
module nfm_addr_track #(
  parameter bit LARGE_PAGE = 1'b0,
  parameter int ROW_W      = 3,
  parameter int PPB_LOG2   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_cnt,
  input  logic [2:0]       ld_val,
  input  logic             area_set,
  input  logic [1:0]       area_val,
  input  logic             clr_all,
  input  logic             blk_align,
  input  logic             col_inc,
  input  logic             addr_go,
  input  logic [7:0]       addr_byte,
  output logic [15:0]      col_q,
  output logic [ROW_W-1:0] row_q,
  output logic [2:0]       acnt_q
);
  import nfm_pkg::*;

  localparam logic [ROW_W-1:0] PG_MASK = ROW_W'((1 << PPB_LOG2) - 1);

  logic [15:0]      col_d;
  logic [ROW_W-1:0] row_d;
  logic [2:0]       acnt_d, acnt_m2;
  logic [1:0]       area_q, area_d;
  logic [31:0]      row_x, byte_mask, byte_put;
  logic             upd;

  assign upd     = clr_all | area_set | ld_cnt | blk_align | col_inc | addr_go;
  assign acnt_m2 = acnt_q - ACNT_ROW0;

  always_comb begin
    col_d     = col_q;
    row_d     = row_q;
    acnt_d    = acnt_q;
    area_d    = area_q;
    row_x     = {{(32-ROW_W){1'b0}}, row_q};
    byte_mask = 32'h0;
    byte_put  = 32'h0;
    if (clr_all) begin
      row_d  = '0;
      col_d  = '0;
      area_d = 2'd0;
    end
    if (area_set)  area_d = area_val;
    if (ld_cnt)    acnt_d = ld_val;
    if (blk_align) row_d  = row_q & ~PG_MASK;
    if (col_inc)   col_d  = col_q + 16'd1;
    if (addr_go && (acnt_q < ACNT_DONE)) begin
      acnt_d = acnt_q + 3'd1;
      if (acnt_q == ACNT_COL0) begin
        if (!LARGE_PAGE) begin
          col_d  = {6'b0, area_q, addr_byte};
          acnt_d = ACNT_ROW0;
          area_d = {area_q[1], 1'b0};
        end else begin
          col_d = {col_q[15:8], addr_byte};
        end
      end else if (acnt_q == 3'd1) begin
        col_d = {addr_byte, col_q[7:0]};
      end else begin
        byte_mask = 32'h0000_00FF << {acnt_m2[1:0], 3'b000};
        byte_put  = {24'h0, addr_byte} << {acnt_m2[1:0], 3'b000};
        row_x     = (row_x & ~byte_mask) | byte_put;
        row_d     = row_x[ROW_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      acnt_q <= ACNT_DONE;
      area_q <= 2'd0;
    end else if (upd) begin
      col_q  <= col_d;
      row_q  <= row_d;
      acnt_q <= acnt_d;
      area_q <= area_d;
    end
  end

endmodule

// File: rtl/nfm_prog_buf.sv
module nfm_prog_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int POS_W      = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_go,
  input  logic [7:0]              wr_byte,
  input  logic [15:0]             col,
  output logic [POS_W-1:0]        pos_q,
  output logic [PAGE_BYTES*8-1:0] buf_flat
);

  logic [7:0]  slot_q [PAGE_BYTES];
  logic [16:0] reach;
  logic        take;

  assign reach = {{(17-POS_W){1'b0}}, pos_q} + {1'b0, col};
  assign take  = wr_go && (reach < 17'(PAGE_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (clr)  pos_q <= '0;
    else if (take) pos_q <= pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) slot_q[pos_q] <= wr_byte;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign buf_flat[g*8 +: 8] = slot_q[g];
  end

endmodule

// File: rtl/nfm_array.sv
module nfm_array #(
  parameter int PAGE_BYTES = 16,
  parameter int NUM_PAGES  = 8,
  parameter int PPB_LOG2   = 1,
  parameter int ROW_W      = 3,
  parameter int POS_W      = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_en,
  input  logic                    erase_en,
  input  logic [ROW_W-1:0]        row,
  input  logic [15:0]             col,
  input  logic [POS_W-1:0]        pos,
  input  logic [PAGE_BYTES*8-1:0] buf_flat,
  output logic [7:0]              rd_byte
);

  localparam int DEPTH = PAGE_BYTES * NUM_PAGES;

  logic [7:0] cell_q [DEPTH];
  logic [7:0] cell_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cell_d[i] = cell_q[i];
      if (erase_en && (((i / PAGE_BYTES) >> PPB_LOG2) == (int'(row) >> PPB_LOG2))) begin
        cell_d[i] = 8'hFF;
      end else if (prog_en && ((i / PAGE_BYTES) == int'(row)) &&
                   ((i % PAGE_BYTES) >= int'(col)) &&
                   (((i % PAGE_BYTES) - int'(col)) < int'(pos))) begin
        cell_d[i] = cell_q[i] & buf_flat[((i % PAGE_BYTES) - int'(col))*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
    end else if (prog_en || erase_en) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= cell_d[i];
    end
  end

  assign rd_byte = (col < 16'(PAGE_BYTES)) ?
                   cell_q[int'(row)*PAGE_BYTES + int'(col)] : 8'h00;

endmodule

// File: rtl/nand_cmd_model.sv
module nand_cmd_model #(
  parameter int         PAGE_BYTES = 16,
  parameter int         NUM_PAGES  = 8,
  parameter int         PPB_LOG2   = 1,
  parameter bit         LARGE_PAGE = 1'b0,
  parameter logic [7:0] MFR_CODE   = 8'hEC,
  parameter logic [7:0] DEV_CODE   = 8'hA1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       addr_we,
  input  logic [7:0] addr_byte,
  input  logic       wr_we,
  input  logic [7:0] wr_byte,
  input  logic       rd_re,
  output logic [7:0] rd_data,
  input  logic       wr_prot,
  output logic       prot_err
);
  import nfm_pkg::*;

  localparam int ROW_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int POS_W = $clog2(PAGE_BYTES + 1);

  nfm_state_e st_q, st_d;
  logic addr_go, wr_go, rd_go;
  logic ld_cnt, area_set, clr_all, blk_align, col_inc, buf_clr;
  logic prog_go, erase_go, err_d;
  logic [2:0] ld_val;
  logic [1:0] area_val;
  logic [15:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [2:0] acnt_q;
  logic [POS_W-1:0] pos_q;
  logic [PAGE_BYTES*8-1:0] buf_flat;
  logic [7:0] arr_byte;

  // one strobe acts per cycle: command, address, write, read
  assign addr_go = addr_we & ~cmd_we;
  assign wr_go   = wr_we & ~cmd_we & ~addr_we;
  assign rd_go   = rd_re & ~cmd_we & ~addr_we & ~wr_we;

  always_comb begin
    st_d      = st_q;
    ld_cnt    = 1'b0;
    ld_val    = ACNT_DONE;
    area_set  = 1'b0;
    area_val  = 2'd0;
    clr_all   = 1'b0;
    blk_align = 1'b0;
    col_inc   = 1'b0;
    buf_clr   = 1'b0;
    prog_go   = 1'b0;
    erase_go  = 1'b0;
    err_d     = 1'b0;
    if (cmd_we) begin
      case (cmd_byte)
        OP_READ: begin
          area_set = 1'b1;
          ld_cnt   = 1'b1;
          ld_val   = ACNT_COL0;
          st_d     = ST_READ;
        end
        OP_AREA1, OP_AREA2: begin
          if (!LARGE_PAGE) begin
            area_set = 1'b1;
            area_val = (cmd_byte == OP_AREA2) ? 2'd2 : 2'd1;
            ld_cnt   = 1'b1;
            ld_val   = ACNT_COL0;
            st_d     = ST_READ;
          end
        end
        OP_PCONF: begin
          if (st_q == ST_PROG) begin
            prog_go = ~wr_prot;
            err_d   = wr_prot;
            st_d    = ST_IDLE;
          end
        end
        OP_ESETUP: begin
          ld_cnt = 1'b1;
          ld_val = ACNT_ROW0;
          st_d   = ST_ERASE;
        end
        OP_PSETUP: begin
          buf_clr = 1'b1;
          ld_cnt  = 1'b1;
          ld_val  = ACNT_COL0;
          st_d    = ST_PROG;
        end
        OP_ECONF: begin
          if (st_q == ST_ERASE) begin
            erase_go  = ~wr_prot;
            err_d     = wr_prot;
            blk_align = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        OP_RESET: begin
          clr_all = 1'b1;
          ld_cnt  = 1'b1;
          st_d    = ST_IDLE;
        end
        OP_STATUS: begin
          ld_cnt = 1'b1;
          st_d   = ST_STAT;
        end
        OP_IDENT: begin
          ld_cnt = 1'b1;
          st_d   = ST_ID0;
        end
        default: ;
      endcase
    end else if (rd_go) begin
      case (st_q)
        ST_READ: col_inc = (col_q < 16'(PAGE_BYTES));
        ST_ID0:  st_d = ST_ID1;
        ST_ID1:  st_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      prot_err <= 1'b0;
    end else begin
      st_q     <= st_d;
      prot_err <= err_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_READ: rd_data = arr_byte;
      ST_STAT: rd_data = {~wr_prot, 7'b100_0000};
      ST_ID0:  rd_data = MFR_CODE;
      ST_ID1:  rd_data = DEV_CODE;
      default: rd_data = 8'h00;
    endcase
  end

  nfm_addr_track #(
    .LARGE_PAGE(LARGE_PAGE), .ROW_W(ROW_W), .PPB_LOG2(PPB_LOG2)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .ld_cnt(ld_cnt), .ld_val(ld_val),
    .area_set(area_set), .area_val(area_val), .clr_all(clr_all),
    .blk_align(blk_align), .col_inc(col_inc), .addr_go(addr_go),
    .addr_byte(addr_byte), .col_q(col_q), .row_q(row_q), .acnt_q(acnt_q)
  );

  nfm_prog_buf #(.PAGE_BYTES(PAGE_BYTES), .POS_W(POS_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_go(wr_go & (st_q == ST_PROG)),
    .wr_byte(wr_byte), .col(col_q), .pos_q(pos_q), .buf_flat(buf_flat)
  );

  nfm_array #(
    .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .PPB_LOG2(PPB_LOG2),
    .ROW_W(ROW_W), .POS_W(POS_W)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_go), .erase_en(erase_go),
    .row(row_q), .col(col_q), .pos(pos_q), .buf_flat(buf_flat),
    .rd_byte(arr_byte)
  );

endmodule

// File: rtl/nand_cmd_model_chk.sv
module nand_cmd_model_chk #(
  parameter int PAGE_BYTES = 16,
  parameter int ROW_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [7:0]       cmd_byte,
  input logic             addr_we,
  input logic             wr_we,
  input logic             rd_re,
  input logic             wr_prot,
  input logic [7:0]       rd_data,
  input logic             prot_err,
  input logic [7:0]       mfr_code,
  input logic [15:0]      col,
  input logic [ROW_W-1:0] row,
  input logic [2:0]       acnt
);

  // R8
  status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte == 8'h70) |=> (rd_data == {~wr_prot, 7'b100_0000}));

  // R9
  ident_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte == 8'h90) |=> (rd_data == mfr_code));

  // R11
  prot_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> ($past(cmd_we) && $past(wr_prot) &&
                  ($past(cmd_byte) == 8'h10 || $past(cmd_byte) == 8'hD0)));

  // R11
  prot_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> !prot_err);

  // R10
  reset_cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte == 8'hFF) |=> (row == '0 && col == 16'd0 && acnt == 3'd6));

  // R10
  addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && addr_we && acnt == 3'd6) |=> ($stable(row) && $stable(col)));

  // R2
  read_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_re && !cmd_we && !addr_we && !wr_we && col >= 16'(PAGE_BYTES)) |=> $stable(col));

  // R12
  cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte == 8'h70) |=> ($stable(col) && $stable(row)));

endmodule

bind nand_cmd_model nand_cmd_model_chk #(
  .PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
  .addr_we(addr_we), .wr_we(wr_we), .rd_re(rd_re), .wr_prot(wr_prot),
  .rd_data(rd_data), .prot_err(prot_err), .mfr_code(MFR_CODE),
  .col(col_q), .row(row_q), .acnt(acnt_q)
);

// File: tb/nand_cmd_model_bench.sv
`timescale 1ns/1ps
module nand_cmd_model_bench;

  localparam int PB = 16;
  localparam int NP = 8;

  logic clk, rst_n;
  logic cmd_we, addr_we, wr_we, rd_re, wr_prot;
  logic [7:0] cmd_byte, addr_byte, wr_byte;
  logic [7:0] rd_s, rd_l;
  logic perr_s, perr_l;
  logic use_lg, done;
  int n_chk, n_err;
  logic [7:0] ref_mem [PB*NP];
  int m_row, m_col;

  nand_cmd_model u_nand_cmd_model (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .addr_we(addr_we), .addr_byte(addr_byte), .wr_we(wr_we), .wr_byte(wr_byte),
    .rd_re(rd_re), .rd_data(rd_s), .wr_prot(wr_prot), .prot_err(perr_s)
  );

  nand_cmd_model #(.LARGE_PAGE(1'b1)) u_nand_cmd_model_lg (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .addr_we(addr_we), .addr_byte(addr_byte), .wr_we(wr_we), .wr_byte(wr_byte),
    .rd_re(rd_re), .rd_data(rd_l), .wr_prot(wr_prot), .prot_err(perr_l)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    cmd_byte = c; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic addr(input logic [7:0] b);
    addr_byte = b; addr_we = 1'b1;
    @(negedge clk);
    addr_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    wr_byte = b; wr_we = 1'b1;
    @(negedge clk);
    wr_we = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    v = use_lg ? rd_l : rd_s;
    rd_re = 1'b1;
    @(negedge clk);
    rd_re = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(v);
    chk(req, v, exp);
  endtask

  function automatic logic [7:0] exp_byte(input int row, input int col);
    return (col < PB) ? ref_mem[row*PB + col] : 8'h00;
  endfunction

  // small-page read with area pointer 0
  task automatic do_read(input int row, input int col, input int n);
    cmd(8'h00); addr(8'(col)); addr(8'(row));
    m_row = row; m_col = col;
    for (int k = 0; k < n; k++) begin
      rd_chk("R2 read stream", exp_byte(m_row, m_col));
      if (m_col < PB) m_col++;
    end
  endtask

  task automatic do_prog(input int row, input int col, input int n,
                         input bit fixed, input logic [7:0] fval, input bit wp);
    logic [7:0] pb [PB];
    int pos;
    logic [7:0] b;
    pos = 0;
    cmd(8'h80); addr(8'(col)); addr(8'(row));
    for (int k = 0; k < n; k++) begin
      b = fixed ? fval : 8'($urandom);
      wr(b);
      if (pos + col < PB) begin pb[pos] = b; pos++; end
    end
    wr_prot = wp;
    cmd(8'h10);
    chk("R11 prot_err on program confirm", {7'b0, perr_s}, {7'b0, wp});
    wr_prot = 1'b0;
    if (!wp) for (int k = 0; k < pos; k++) ref_mem[row*PB + col + k] &= pb[k];
    rd_chk("R6 idle after confirm", 8'h00);
    m_row = row; m_col = col;
  endtask

  task automatic do_erase(input int row, input bit wp);
    cmd(8'h60); addr(8'(row));
    wr_prot = wp;
    cmd(8'hD0);
    chk("R11 prot_err on erase confirm", {7'b0, perr_s}, {7'b0, wp});
    wr_prot = 1'b0;
    if (!wp) for (int k = (row & ~1) * PB; k < ((row & ~1) + 2) * PB; k++) ref_mem[k] = 8'hFF;
    m_row = row & ~1;
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed, op, row, col, n;
    seed = $urandom(32'd2024);
    n_chk = 0; n_err = 0; use_lg = 1'b0;
    cmd_we = 0; addr_we = 0; wr_we = 0; rd_re = 0; wr_prot = 0;
    cmd_byte = 0; addr_byte = 0; wr_byte = 0;
    for (int i = 0; i < PB*NP; i++) ref_mem[i] = 8'hFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rd_data after reset", rd_s, 8'h00);
    chk("R1 prot_err after reset", {7'b0, perr_s}, 8'h00);
    do_read(7, 0, 3);

    // R8 status
    cmd(8'h70);
    rd_chk("R8 status writable", 8'hC0);
    wr_prot = 1'b1;
    @(negedge clk);
    rd_chk("R8 status protected", 8'h40);
    wr_prot = 1'b0;
    // R13 unknown commands keep status mode
    cmd(8'h42); cmd(8'h30);
    rd_chk("R13 unknown command ignored", 8'hC0);

    // R9 identification
    cmd(8'h90);
    rd_chk("R9 manufacturer", 8'hEC);
    rd_chk("R9 device", 8'hA1);
    rd_chk("R9 idle afterwards", 8'h00);

    // random mix
    for (int it = 0; it < 60; it++) begin
      op = int'($urandom % 3);
      row = int'($urandom % NP);
      col = int'($urandom % PB);
      n = 1 + int'($urandom % 20);
      case (op)
        0: do_prog(row, col, n, 1'b0, 8'h00, ($urandom % 8) == 0);
        1: do_erase(row, ($urandom % 6) == 0);
        default: do_read(row, col, n);
      endcase
    end
    do_prog(1, 2, 5, 1'b0, 8'h00, 1'b0);
    do_read(1, 0, 16);

    // R5 drop past end of page
    do_erase(5, 1'b0);
    do_prog(5, 14, 4, 1'b1, 8'h00, 1'b0);
    do_read(5, 13, 4);
    chk("R5 buffered tail", ref_mem[5*PB+15], 8'h00);

    // R11 protected program leaves array
    do_prog(4, 0, 3, 1'b1, 8'h00, 1'b1);
    chk("R11 prot_err single cycle", {7'b0, perr_s}, 8'h00);
    do_read(4, 0, 3);

    // R7 erase aligns row, confirm only after setup
    do_prog(2, 0, 2, 1'b1, 8'h00, 1'b0);
    do_erase(3, 1'b0);
    cmd(8'h80); wr(8'h00); cmd(8'h10);
    ref_mem[2*PB] = 8'h00;
    m_row = 2;
    do_read(2, 0, 1);
    do_read(3, 0, 1);
    chk("R7 aligned row programmed", ref_mem[2*PB], 8'h00);
    cmd(8'hD0);
    do_read(2, 0, 2);

    // R6 confirm outside program setup
    do_erase(6, 1'b0);
    cmd(8'h80); addr(8'h00); addr(8'h06); wr(8'h00);
    cmd(8'h00); cmd(8'h10);
    do_read(6, 0, 1);
    chk("R6 stray confirm", ref_mem[6*PB], 8'hFF);

    // R10 reset command and ignored address bytes
    ref_mem[0] = 8'h5A; ref_mem[1] = 8'h00;
    do_prog(0, 0, 2, 1'b1, 8'h00, 1'b0);
    ref_mem[0] = 8'h00;
    do_prog(0, 0, 1, 1'b1, 8'h00, 1'b0);
    do_read(3, 9, 1);
    cmd(8'hFF); cmd(8'h00);
    rd_chk("R10 row and column cleared", ref_mem[0]);
    cmd(8'h90); addr(8'h05); addr(8'h03);
    cmd(8'h00);
    rd_chk("R10 address bytes ignored", ref_mem[1]);

    // R3 area pointers on small pages
    do_prog(2, 3, 1, 1'b1, 8'h00, 1'b0);
    cmd(8'h01); addr(8'h04); addr(8'h02);
    rd_chk("R3 area 1 column beyond page", 8'h00);
    rd_chk("R3 column held past end", 8'h00);
    cmd(8'h80); addr(8'h03); addr(8'h02); cmd(8'h00);
    rd_chk("R3 area 1 applies once", ref_mem[2*PB+3]);
    cmd(8'h50); addr(8'h01); addr(8'h02);
    rd_chk("R3 area 2 column", 8'h00);
    cmd(8'h80); addr(8'h03); addr(8'h02); cmd(8'h00);
    rd_chk("R3 area 2 persists", 8'h00);
    cmd(8'hFF);

    // R12 same-cycle strobes
    do_prog(4, 2, 2, 1'b1, 8'h00, 1'b0);
    do_read(4, 2, 1);
    cmd_byte = 8'h70; cmd_we = 1'b1; rd_re = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; rd_re = 1'b0;
    cmd(8'h00);
    rd_chk("R12 read lost to command", ref_mem[4*PB+3]);
    do_erase(7, 1'b0);
    cmd(8'h80); addr(8'h00); addr(8'h07);
    addr_byte = 8'h00; wr_byte = 8'h00; addr_we = 1'b1; wr_we = 1'b1;
    @(negedge clk);
    addr_we = 1'b0; wr_we = 1'b0;
    cmd(8'h10);
    do_read(7, 0, 1);
    chk("R12 write lost to address", ref_mem[7*PB], 8'hFF);

    // R4 large-page instance
    use_lg = 1'b1;
    cmd(8'hFF);
    cmd(8'h80); addr(8'h05); addr(8'h00); addr(8'h0B); addr(8'h00);
    wr(8'h3C); wr(8'h5A);
    cmd(8'h10);
    cmd(8'h00); addr(8'h04); addr(8'h00); addr(8'h03);
    rd_chk("R4 large byte before", 8'hFF);
    rd_chk("R4 large first byte, row masked", 8'h3C);
    rd_chk("R4 large second byte", 8'h5A);
    rd_chk("R4 large byte after", 8'hFF);
    cmd(8'h00); addr(8'h06); addr(8'h01); addr(8'h03);
    rd_chk("R4 column high byte used", 8'h00);
    cmd(8'h70); cmd(8'h01);
    rd_chk("R4 area command rejected", 8'hC0);
    cmd(8'h50);
    rd_chk("R4 area 2 command rejected", 8'hC0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule